// File: doc/BRIEF.md
# Platform System Control Register File

This block is a byte-wide register file on a simple synchronous I/O bus. It decodes a small set of port addresses. Some ports hold platform control state: a soft-reset request, a little-endian mode flag, a disk activity light, a 4-bit system control field and an I/O map type bit. Other ports return fixed identity and feature bytes. A write to either of the two password ports sends a one-cycle lock-toggle pulse, tagged with a selector, to an external NVRAM controller.

A host issues one access per cycle using a read strobe or a write strobe, an address and write data. Read data is registered and appears on the cycle after the read strobe. Ports the block does not decode read as all ones, and writes to them are dropped.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset, the reset request, little-endian flag, light, control field and map type are all 0, and no lock pulse is active.
- R2: A write to port 0x092 sets the reset request output to data bit 0. The output holds that level until the next write to 0x092.
- R3: A write to port 0x092 sets the little-endian flag to data bit 1. A read of 0x092 returns the flag in bit 1 and 0 in every other bit.
- R4: Ports 0x800, 0x802 and 0x803 read as 0xEF, 0xAD and 0xE0. A write to any of them changes no output and no readable value.
- R5: Ports 0x80C, 0x810, 0x818 and 0x823 read as 0x3C, 0x39, 0x00 and 0x03.
- R6: A write to port 0x808 sets the light output to data bit 0 and leaves all other state unchanged.
- R7: A write to port 0x810 raises the lock pulse for exactly one cycle with selector 1 (encoded as 2'b01). A write to port 0x812 does the same with selector 2 (2'b10). The written data is ignored.
- R8: A write to port 0x81C stores data bits 3:0. A read of 0x81C returns the stored value in bits 3:0 with bits 7:4 zero.
- R9: A write to port 0x850 stores data bit 0 as the map type and drives it on the map output. A read of 0x850 returns the stored bit in bit 0 and 0 elsewhere.
- R10: A read of any port that is not decoded returns 0xFF, and a write to such a port changes no state.
- R11: Port 0x814 reads as 0xFF, and a write to it changes no state.
- R12: Read data appears on the rd_data port one cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Port address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| soft_rst_req | output | 1 | Soft reset request level |
| le_mode | output | 1 | Little-endian mode flag |
| disk_light | output | 1 | Disk activity indicator |
| map_type | output | 1 | I/O map type |
| lock_pulse | output | 1 | One-cycle lock toggle strobe |
| lock_sel | output | 2 | Lock selector (1 or 2) while the pulse is high |

## Verification
The hardest case to reach is the shared control port 0x092. It holds two independent settings, and a stray write elsewhere must not disturb them. The bench therefore first puts known values into all stored state, then sends random writes to read-only, dead and unmapped ports. After that it reads every state port back and checks every output. Pulses from back-to-back password writes are sampled each cycle to confirm that each pulse lasts a single cycle and carries the right selector.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int AW = 12;
  localparam int DW = 8;
  localparam int CW = 4;

  localparam logic [AW-1:0] P_CTL92  = 12'h092;
  localparam logic [AW-1:0] P_CPUCFG = 12'h800;
  localparam logic [AW-1:0] P_FEAT   = 12'h802;
  localparam logic [AW-1:0] P_STAT   = 12'h803;
  localparam logic [AW-1:0] P_LIGHT  = 12'h808;
  localparam logic [AW-1:0] P_EQUIP  = 12'h80C;
  localparam logic [AW-1:0] P_PWD1   = 12'h810;
  localparam logic [AW-1:0] P_PWD2   = 12'h812;
  localparam logic [AW-1:0] P_L2INV  = 12'h814;
  localparam logic [AW-1:0] P_KEY    = 12'h818;
  localparam logic [AW-1:0] P_SYSC   = 12'h81C;
  localparam logic [AW-1:0] P_L2ST   = 12'h823;
  localparam logic [AW-1:0] P_MAP    = 12'h850;

  typedef struct packed {
    logic          rst_req;
    logic          le;
    logic          light;
    logic [CW-1:0] sysc;
    logic          map;
  } ctl_state_t;

  // Fixed byte for a constant port; hit says whether the port is a constant one.
  function automatic logic [DW:0] const_byte(input logic [AW-1:0] a);
    case (a)
      P_CPUCFG: const_byte = {1'b1, 8'hEF};
      P_FEAT:   const_byte = {1'b1, 8'hAD};
      P_STAT:   const_byte = {1'b1, 8'hE0};
      P_EQUIP:  const_byte = {1'b1, 8'h3C};
      P_PWD1:   const_byte = {1'b1, 8'h39};
      P_KEY:    const_byte = {1'b1, 8'h00};
      P_L2ST:   const_byte = {1'b1, 8'h03};
      default:  const_byte = {1'b0, 8'hFF};
    endcase
  endfunction
endpackage

// File: rtl/sysctl_wdec.sv
module sysctl_wdec
  import sysctl_pkg::*;
(
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  output logic          we_ctl,
  output logic          we_light,
  output logic          we_sysc,
  output logic          we_map,
  output logic          we_pwd1,
  output logic          we_pwd2
);
  always_comb begin
    we_ctl   = wr_en && (addr == P_CTL92);
    we_light = wr_en && (addr == P_LIGHT);
    we_sysc  = wr_en && (addr == P_SYSC);
    we_map   = wr_en && (addr == P_MAP);
    we_pwd1  = wr_en && (addr == P_PWD1);
    we_pwd2  = wr_en && (addr == P_PWD2);
  end
endmodule

// File: rtl/sysctl_state.sv
module sysctl_state
  import sysctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_ctl,
  input  logic          we_light,
  input  logic          we_sysc,
  input  logic          we_map,
  input  logic          we_pwd1,
  input  logic          we_pwd2,
  input  logic [DW-1:0] wdat,
  output ctl_state_t    st,
  output logic          pulse,
  output logic [1:0]    sel
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= '0;
      pulse <= 1'b0;
      sel   <= 2'b00;
    end else begin
      if (we_ctl) begin
        st.rst_req <= wdat[0];
        st.le      <= wdat[1];
      end
      if (we_light) st.light <= wdat[0];
      if (we_sysc)  st.sysc  <= wdat[CW-1:0];
      if (we_map)   st.map   <= wdat[0];
      pulse <= we_pwd1 | we_pwd2;
      sel   <= we_pwd1 ? 2'b01 : (we_pwd2 ? 2'b10 : 2'b00);
    end
  end
endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
  import sysctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  ctl_state_t    st,
  output logic [DW-1:0] rdat
);
  logic [DW-1:0] nxt;
  logic [DW:0]   cb;

  always_comb begin
    cb = const_byte(addr);
    case (addr)
      P_CTL92: nxt = {6'b0, st.le, 1'b0};
      P_SYSC:  nxt = {{(DW-CW){1'b0}}, st.sysc};
      P_MAP:   nxt = {7'b0, st.map};
      default: nxt = cb[DW-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdat <= '0;
    else if (rd_en) rdat <= nxt;
  end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [11:0]   addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data,
  output logic          soft_rst_req,
  output logic          le_mode,
  output logic          disk_light,
  output logic          map_type,
  output logic          lock_pulse,
  output logic [1:0]    lock_sel
);
  logic we_ctl, we_light, we_sysc, we_map, we_pwd1, we_pwd2;
  ctl_state_t st;

  sysctl_wdec u_wdec (
    .wr_en(wr_en), .addr(addr),
    .we_ctl(we_ctl), .we_light(we_light), .we_sysc(we_sysc),
    .we_map(we_map), .we_pwd1(we_pwd1), .we_pwd2(we_pwd2)
  );

  sysctl_state u_state (
    .clk(clk), .rst_n(rst_n),
    .we_ctl(we_ctl), .we_light(we_light), .we_sysc(we_sysc),
    .we_map(we_map), .we_pwd1(we_pwd1), .we_pwd2(we_pwd2),
    .wdat(wr_data), .st(st), .pulse(lock_pulse), .sel(lock_sel)
  );

  sysctl_rdmux u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
    .st(st), .rdat(rd_data)
  );

  assign soft_rst_req = st.rst_req;
  assign le_mode      = st.le;
  assign disk_light   = st.light;
  assign map_type     = st.map;
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [11:0] addr,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       soft_rst_req,
  input logic       le_mode,
  input logic       disk_light,
  input logic       map_type,
  input logic       lock_pulse,
  input logic [1:0] lock_sel
);
  // R2
  rst_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 12'h092) |=> $stable(soft_rst_req));
  // R2
  rst_req_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 12'h092) |=> soft_rst_req == $past(wr_data[0]));
  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_pulse && !$past(wr_en && (addr == 12'h810 || addr == 12'h812)) |-> 1'b0);
  // R7
  pulse_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_pulse |-> $onehot0(lock_sel) && lock_sel != 2'b00);
  // R6
  light_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 12'h808) |=> $stable(disk_light));
  // R9
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 12'h850) |=> $stable(map_type));
  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind sysctl_regfile sysctl_regfile_chk u_chk (.*);

// File: tb/sysctl_regfile_bench.sv
module sysctl_regfile_bench;
  logic clk = 0, rst_n = 0;
  logic [11:0] addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic soft_rst_req, le_mode, disk_light, map_type, lock_pulse;
  logic [1:0] lock_sel;
  int total = 0, bad = 0;
  logic m_rst, m_le, m_light, m_map;
  logic [3:0] m_sysc;

  always #2.5 clk = ~clk;

  sysctl_regfile u_sysctl_regfile (.*);

  function automatic logic [7:0] exp_rd(input logic [11:0] a);
    if (a == 12'h092) return {6'd0, m_le, 1'b0};
    if (a == 12'h81C) return {4'd0, m_sysc};
    if (a == 12'h850) return {7'd0, m_map};
    if (a == 12'h800) return 8'hEF;
    if (a == 12'h802) return 8'hAD;
    if (a == 12'h803) return 8'hE0;
    if (a == 12'h80C) return 8'h3C;
    if (a == 12'h810) return 8'h39;
    if (a == 12'h818) return 8'h00;
    if (a == 12'h823) return 8'h03;
    return 8'hFF;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
    if (a == 12'h092) begin m_rst = d[0]; m_le = d[1]; end
    if (a == 12'h808) m_light = d[0];
    if (a == 12'h81C) m_sysc = d[3:0];
    if (a == 12'h850) m_map = d[0];
  endtask

  task automatic rd(input string req, input logic [11:0] a);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0;
    chk(req, rd_data, exp_rd(a));
  endtask

  task automatic outs(input string req);
    chk(req, {soft_rst_req, le_mode, disk_light, map_type},
        {m_rst, m_le, m_light, m_map});
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd77));
    m_rst = 0; m_le = 0; m_light = 0; m_map = 0; m_sysc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    outs("R1"); chk("R1", lock_pulse, 0);
    rd("R1", 12'h81C);
    // R2 R3
    wr(12'h092, 8'h01); outs("R2"); rd("R3", 12'h092);
    wr(12'h092, 8'h02); outs("R2"); rd("R3", 12'h092);
    wr(12'h092, 8'hFF); outs("R3"); rd("R3", 12'h092);
    // R4 R5
    rd("R4", 12'h800); rd("R4", 12'h802); rd("R4", 12'h803);
    wr(12'h800, 8'h00); wr(12'h802, 8'h55); wr(12'h803, 8'h12);
    rd("R4", 12'h800); rd("R4", 12'h803); outs("R4"); rd("R4", 12'h092);
    rd("R5", 12'h80C); rd("R5", 12'h810); rd("R5", 12'h818); rd("R5", 12'h823);
    // R6 R8 R9
    wr(12'h808, 8'hFF); outs("R6");
    wr(12'h808, 8'hFE); outs("R6");
    wr(12'h81C, 8'hA7); rd("R8", 12'h81C);
    wr(12'h850, 8'h03); outs("R9"); rd("R9", 12'h850);
    // R7: back-to-back password writes
    @(negedge clk); addr = 12'h810; wr_data = 8'h00; wr_en = 1;
    @(negedge clk); addr = 12'h812; wr_data = 8'hFF;
    chk("R7", {lock_pulse, lock_sel}, 3'b101);
    @(negedge clk); wr_en = 0;
    chk("R7", {lock_pulse, lock_sel}, 3'b110);
    @(negedge clk);
    chk("R7", lock_pulse, 0);
    // R11
    wr(12'h814, 8'hFF); outs("R11"); rd("R11", 12'h814);
    // R10 and random traffic
    for (int i = 0; i < 300; i++) begin
      logic [11:0] a;
      logic [7:0] d;
      int k;
      k = $urandom_range(0, 3);
      case (k)
        0: a = 12'($urandom_range(0, 4095));
        1: a = 12'h800 + 12'($urandom_range(0, 8'h55));
        2: a = 12'h092;
        default: a = 12'h81C;
      endcase
      d = 8'($urandom);
      if (a == 12'h810 || a == 12'h812) a = 12'h814;
      if ($urandom_range(0, 1) == 0) begin
        wr(a, d); outs("R10");
      end else begin
        rd("R10", a);
      end
    end
    rd("R10", 12'hFFF); rd("R10", 12'h851);
    // R12: data holds without a read
    rd("R12", 12'h802);
    repeat (3) @(negedge clk);
    chk("R12", rd_data, 8'hAD);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule